// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Sequencing

This block turns parallel characters into an asynchronous serial stream on a single output line. One character can wait in a holding register while the previous one is shifted out, and consecutive frames follow each other with no idle gap. Bit timing comes from a free-running tick at sixteen times the bit rate, supplied from outside. Character length, parity mode and the number of stop bits are fixed when the block is instantiated.

A command decoder drives single-cycle strobes into the block. These strobes turn the transmitter on or off, and they begin or end a line break, which holds the line low. A break request waits behind the character being shifted and behind every character loaded into the holding register before the break actually starts. Ending a break always leaves a full marking bit period before the next frame. Turning the transmitter off stops new traffic from being accepted, but characters already accepted are still sent in full.

Top module: `sertx_brk`

## Requirements
- R1: After reset, `txd` is 1, and `rdy` and `empty` are both 0 because the transmitter starts disabled.
- R2: `en_stb` enables the transmitter, after which `rdy` and `empty` read 1 when nothing is pending. A cycle that carries both `en_stb` and `dis_stb` leaves the transmitter disabled.
- R3: Each frame has a low start bit, `DATA_W` data bits sent least significant bit first, an optional parity bit (PARITY 0 = none, 1 = even, 2 = odd) and `STOP_BITS` high stop bits. Every bit lasts `OVS` ticks.
- R4: A write with `wr_en` while `rdy` is 1 is captured into the holding register, and `rdy` reads 0 on the following cycle. A character waiting in the holding register when a stop bit ends starts on the very next tick, so consecutive frame starts are exactly one frame length apart.
- R5: A write while `rdy` is 0 is ignored. This covers both a full holding register and a disabled transmitter, and no such character ever appears on `txd`.
- R6: A break requested while a character is shifting or held starts only after that character and any character written before the break begins have been sent. The line then stays low until the break is ended.
- R7: A break requested while the transmitter is idle drives `txd` low within two bit times.
- R8: `brk_start` is ignored while the transmitter is disabled, and `txd` stays high.
- R9: After `brk_stop` ends an active break, `txd` is high within two bit times. It stays high for at least `OVS` ticks before any following start bit.
- R10: `dis_stb` drops `rdy` and `empty` on the next cycle. A character that was shifting and a character that was held are both still sent completely.
- R11: `empty` is 1 only when the transmitter is enabled, nothing is shifting, the holding register is empty, and no break is active or waiting.
- R12: A `brk_stop` that arrives before a queued break has started cancels that break, so the line never goes low for it. When `brk_start` and `brk_stop` arrive in the same cycle, the stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| en_stb | input | 1 | Enable-transmitter strobe |
| dis_stb | input | 1 | Graceful disable strobe |
| brk_start | input | 1 | Begin-break command strobe |
| brk_stop | input | 1 | End-break command strobe |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Character to send |
| txd | output | 1 | Serial line, high when marking |
| rdy | output | 1 | Holding register can accept a character |
| empty | output | 1 | Nothing shifting, held or in break |

## Verification
Two functions can land in the same cycle: loading a character into the holding register, and the engine choosing between the next character and a queued break at the end of a stop bit. The bench provokes this by writing a third character after a break request is already queued, while the second character is on the line. It judges the result by counting how many complete frames the line decoder has recovered when the long low run is first seen. The bench also pulses start and stop break in the same cycle, and enable with disable, and checks which one wins at the ports.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      TX_IDLE  = 3'd0,
      TX_START = 3'd1,
      TX_DATA  = 3'd2,
      TX_STOP  = 3'd3,
      TX_BRK   = 3'd4,
      TX_MARK  = 3'd5
   } tx_state_e;

   localparam int PAR_NONE = 0;
   localparam int PAR_EVEN = 1;
   localparam int PAR_ODD  = 2;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic              full,
   output logic [DATA_W-1:0] data
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (push) begin
            full_q <= 1'b1;
            data_q <= push_data;
         end else if (pop) begin
            full_q <= 1'b0;
         end
      end
   end

   assign full = full_q;
   assign data = data_q;

   assert_no_overflow_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full_q);

   assert_pop_only_full_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> full_q);

endmodule

// File: rtl/sertx_ctl.sv
module sertx_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic en_stb,
   input  logic dis_stb,
   input  logic brk_start,
   input  logic brk_stop,
   input  logic brk_take,
   input  logic brk_on,
   input  logic brk_done,
   output logic en_q,
   output logic brk_pend,
   output logic brk_end_req
);

   logic en_r, pend_r, endreq_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_r     <= 1'b0;
         pend_r   <= 1'b0;
         endreq_r <= 1'b0;
      end else begin
         if (dis_stb)     en_r <= 1'b0;
         else if (en_stb) en_r <= 1'b1;

         if (brk_stop || brk_take)                   pend_r <= 1'b0;
         else if (brk_start && en_r && !brk_on)      pend_r <= 1'b1;

         if (brk_done)                               endreq_r <= 1'b0;
         else if (brk_stop && (brk_on || brk_take))  endreq_r <= 1'b1;
      end
   end

   assign en_q        = en_r;
   assign brk_pend    = pend_r;
   assign brk_end_req = endreq_r;

   assert_brk_needs_en_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_r) |-> $past(en_r));

   assert_stop_cancels_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      brk_stop |=> !pend_r);

endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
   import sertx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PARITY    = 0,
   parameter int STOP_BITS = 1,
   parameter int OVS       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hold_vld,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              brk_pend,
   input  logic              end_req,
   output logic              pop,
   output logic              brk_take,
   output logic              brk_on,
   output logic              brk_done,
   output logic              idle,
   output logic              txd
);

   localparam int NBITS  = DATA_W + ((PARITY != PAR_NONE) ? 1 : 0);
   localparam int STOP_T = OVS * STOP_BITS;
   localparam int TW     = $clog2(STOP_T);
   localparam int BW     = $clog2(NBITS);
   localparam logic [TW-1:0] BIT_END  = TW'(OVS - 1);
   localparam logic [TW-1:0] STOP_END = TW'(STOP_T - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

   logic [NBITS-1:0] frame;

   generate
      if (PARITY == PAR_NONE) begin : g_nopar
         assign frame = hold_data;
      end else begin : g_par
         logic pbit;
         assign pbit  = (^hold_data) ^ (PARITY == PAR_ODD);
         assign frame = {pbit, hold_data};
      end
   endgenerate

   tx_state_e        state_q, state_d;
   logic [TW-1:0]    tcnt_q, tcnt_d;
   logic [BW-1:0]    bcnt_q, bcnt_d;
   logic [NBITS-1:0] sh_q, sh_d;

   always_comb begin
      state_d  = state_q;
      tcnt_d   = tcnt_q;
      bcnt_d   = bcnt_q;
      sh_d     = sh_q;
      pop      = 1'b0;
      brk_take = 1'b0;
      brk_done = 1'b0;
      if (tick) begin
         unique case (state_q)
            TX_IDLE: begin
               if (hold_vld) begin
                  state_d = TX_START;
                  tcnt_d  = '0;
                  sh_d    = frame;
                  pop     = 1'b1;
               end else if (brk_pend) begin
                  state_d  = TX_BRK;
                  brk_take = 1'b1;
               end
            end
            TX_START: begin
               if (tcnt_q == BIT_END) begin
                  state_d = TX_DATA;
                  tcnt_d  = '0;
                  bcnt_d  = '0;
               end else begin
                  tcnt_d = tcnt_q + 1'b1;
               end
            end
            TX_DATA: begin
               if (tcnt_q == BIT_END) begin
                  tcnt_d = '0;
                  sh_d   = sh_q >> 1;
                  if (bcnt_q == LAST_BIT) state_d = TX_STOP;
                  else                    bcnt_d  = bcnt_q + 1'b1;
               end else begin
                  tcnt_d = tcnt_q + 1'b1;
               end
            end
            TX_STOP: begin
               if (tcnt_q == STOP_END) begin
                  tcnt_d = '0;
                  if (hold_vld) begin
                     state_d = TX_START;
                     sh_d    = frame;
                     pop     = 1'b1;
                  end else if (brk_pend) begin
                     state_d  = TX_BRK;
                     brk_take = 1'b1;
                  end else begin
                     state_d = TX_IDLE;
                  end
               end else begin
                  tcnt_d = tcnt_q + 1'b1;
               end
            end
            TX_BRK: begin
               if (end_req) begin
                  state_d  = TX_MARK;
                  tcnt_d   = '0;
                  brk_done = 1'b1;
               end
            end
            TX_MARK: begin
               if (tcnt_q == BIT_END) begin
                  state_d = TX_IDLE;
                  tcnt_d  = '0;
               end else begin
                  tcnt_d = tcnt_q + 1'b1;
               end
            end
            default: state_d = TX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         tcnt_q  <= '0;
         bcnt_q  <= '0;
         sh_q    <= '0;
      end else begin
         state_q <= state_d;
         tcnt_q  <= tcnt_d;
         bcnt_q  <= bcnt_d;
         sh_q    <= sh_d;
      end
   end

   always_comb begin
      unique case (state_q)
         TX_START: txd = 1'b0;
         TX_DATA:  txd = sh_q[0];
         TX_BRK:   txd = 1'b0;
         default:  txd = 1'b1;
      endcase
   end

   assign idle   = (state_q == TX_IDLE);
   assign brk_on = (state_q == TX_BRK);

   assert_stop_leaves_break_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (brk_on && end_req && tick) |=> (txd && state_q == TX_MARK));

   assert_break_exits_to_mark_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_BRK) |=> (state_q == TX_BRK || state_q == TX_MARK));

   assert_take_after_chars_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      brk_take |-> (!hold_vld && brk_pend));

endmodule

// File: rtl/sertx_brk.sv
module sertx_brk #(
   parameter int DATA_W    = 8,
   parameter int PARITY    = 0,
   parameter int STOP_BITS = 1,
   parameter int OVS       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en_stb,
   input  logic              dis_stb,
   input  logic              brk_start,
   input  logic              brk_stop,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              rdy,
   output logic              empty
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("sertx_brk: DATA_W must lie in 5..9");
      end
      if (PARITY < 0 || PARITY > 2) begin : g_bad_parity
         $error("sertx_brk: PARITY must be 0, 1 or 2");
      end
      if (STOP_BITS < 1 || STOP_BITS > 2) begin : g_bad_stop
         $error("sertx_brk: STOP_BITS must be 1 or 2");
      end
      if (OVS < 4) begin : g_bad_ovs
         $error("sertx_brk: OVS must be at least 4");
      end
   endgenerate

   logic              en_q, brk_pend, brk_end_req;
   logic              brk_take, brk_on, brk_done;
   logic              hold_full, pop, push, eng_idle;
   logic [DATA_W-1:0] hold_data;

   assign push  = wr_en && en_q && !hold_full;
   assign rdy   = en_q && !hold_full;
   assign empty = rdy && eng_idle && !brk_pend;

   sertx_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_stb     (en_stb),
      .dis_stb    (dis_stb),
      .brk_start  (brk_start),
      .brk_stop   (brk_stop),
      .brk_take   (brk_take),
      .brk_on     (brk_on),
      .brk_done   (brk_done),
      .en_q       (en_q),
      .brk_pend   (brk_pend),
      .brk_end_req(brk_end_req)
   );

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_data(wr_data),
      .pop      (pop),
      .full     (hold_full),
      .data     (hold_data)
   );

   sertx_engine #(
      .DATA_W   (DATA_W),
      .PARITY   (PARITY),
      .STOP_BITS(STOP_BITS),
      .OVS      (OVS)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .hold_vld (hold_full),
      .hold_data(hold_data),
      .brk_pend (brk_pend),
      .end_req  (brk_end_req),
      .pop      (pop),
      .brk_take (brk_take),
      .brk_on   (brk_on),
      .brk_done (brk_done),
      .idle     (eng_idle),
      .txd      (txd)
   );

   assert_rdy_drop_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rdy) |=> !rdy);

   assert_empty_marks_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> txd);

   assert_disable_drops_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      dis_stb |=> (!rdy && !empty));

endmodule

// File: tb/sertx_brk_bench.sv
`timescale 1ns/1ps
module sertx_brk_bench;

   localparam int DW    = 8;
   localparam int OV    = 16;
   localparam int FRAME = OV * (DW + 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic en_stb = 1'b0, dis_stb = 1'b0, brk_start = 1'b0, brk_stop = 1'b0;
   logic wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic txd, rdy, empty;

   always #2.5 clk = ~clk;

   sertx_brk u_sertx_brk (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .en_stb(en_stb), .dis_stb(dis_stb),
      .brk_start(brk_start), .brk_stop(brk_stop),
      .wr_en(wr_en), .wr_data(wr_data),
      .txd(txd), .rdy(rdy), .empty(empty)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // tick generator: one pulse every third cycle, changed just after the edge
   initial begin
      int div = 0;
      forever begin
         @(posedge clk);
         #1;
         tick = (div == 0);
         div = (div + 1) % 3;
      end
   end

   // line decoder
   logic [DW-1:0] exp_q[$];
   int start_log[$];
   int samp_n = 0;
   int mstate = 0;
   int cnt = 0;
   int high_run = 0;
   bit after_brk = 0;
   int rx_total = 0;
   int brk_events = 0;
   int chars_at_brk = 0;
   logic [DW-1:0] rx_sh = '0;

   always @(negedge clk) begin
      if (rst_n && tick) begin
         samp_n++;
         case (mstate)
            0: begin
               if (txd == 1'b0) begin
                  if (after_brk) chk(high_run >= OV, "R9 mark time", high_run, OV);
                  after_brk = 0;
                  mstate = 1;
                  cnt = 1;
                  start_log.push_back(samp_n);
               end else begin
                  high_run++;
               end
            end
            1: begin
               cnt++;
               if (cnt % OV == OV / 2) begin
                  if (cnt / OV == 0) begin
                     chk(txd == 1'b0, "R3 start bit", int'(txd), 0);
                  end else if (cnt / OV <= DW) begin
                     rx_sh = {txd, rx_sh[DW-1:1]};
                  end else begin
                     if (txd == 1'b1) begin
                        rx_total++;
                        if (exp_q.size() == 0) begin
                           chk(1'b0, "R3/R5 unexpected char", int'(rx_sh), 0);
                        end else begin
                           logic [DW-1:0] e;
                           e = exp_q.pop_front();
                           chk(rx_sh == e, "R3 char data", int'(rx_sh), int'(e));
                        end
                        mstate = 0;
                        high_run = 0;
                     end else begin
                        chk(rx_sh == '0, "R6 break pattern", int'(rx_sh), 0);
                        void'(start_log.pop_back());
                        brk_events++;
                        chars_at_brk = rx_total;
                        mstate = 2;
                     end
                  end
               end
            end
            default: begin
               if (txd == 1'b1) begin
                  mstate = 0;
                  after_brk = 1;
                  high_run = 1;
               end
            end
         endcase
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ticks(input int n);
      int k = n;
      while (k > 0) begin
         @(negedge clk);
         if (tick) k--;
      end
   endtask

   task automatic pulse_en();  en_stb = 1;  @(negedge clk); en_stb = 0;  endtask
   task automatic pulse_dis(); dis_stb = 1; @(negedge clk); dis_stb = 0; endtask
   task automatic pulse_bstart(); brk_start = 1; @(negedge clk); brk_start = 0; endtask
   task automatic pulse_bstop();  brk_stop = 1;  @(negedge clk); brk_stop = 0;  endtask

   task automatic wait_rdy();
      int g = 0;
      while (!rdy && g < 5000) begin @(negedge clk); g++; end
   endtask

   task automatic wait_empty();
      int g = 0;
      while (!empty && g < 8000) begin @(negedge clk); g++; end
      chk(empty == 1'b1, "R11 drain to empty", int'(empty), 1);
   endtask

   // write after rdy is seen; expected queue follows the requirement
   task automatic put(input logic [DW-1:0] d);
      wait_rdy();
      wr_en = 1; wr_data = d;
      exp_q.push_back(d);
      @(negedge clk);
      wr_en = 0;
      chk(rdy == 1'b0, "R4 rdy drops after write", int'(rdy), 0);
   endtask

   task automatic wait_rx(input int target);
      int g = 0;
      while (rx_total < target && g < 10000) begin @(negedge clk); g++; end
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd4242);
      cyc(3);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
      chk(rdy == 1'b0, "R1 rdy", int'(rdy), 0);
      chk(empty == 1'b0, "R1 empty", int'(empty), 0);
      rst_n = 1;
      cyc(3);

      // R2 enable and disable together: disable wins
      en_stb = 1; dis_stb = 1; @(negedge clk); en_stb = 0; dis_stb = 0;
      chk(rdy == 1'b0, "R2 dis wins", int'(rdy), 0);
      pulse_en();
      chk(rdy == 1'b1, "R2 rdy after enable", int'(rdy), 1);
      chk(empty == 1'b1, "R2 empty after enable", int'(empty), 1);

      // R4 back-to-back and R5 write into full holding register
      begin
         int s0;
         s0 = start_log.size();
         put(8'hA5);
         put(8'h3C);
         chk(empty == 1'b0, "R11 busy not empty", int'(empty), 0);
         wr_en = 1; wr_data = 8'hEE; @(negedge clk); wr_en = 0;
         chk(rdy == 1'b0, "R5 full stays not ready", int'(rdy), 0);
         wait_rx(rx_total + 2);
         wait_empty();
         chk(start_log.size() == s0 + 2, "R4 two frames", start_log.size() - s0, 2);
         if (start_log.size() == s0 + 2)
            chk(start_log[s0+1] - start_log[s0] == FRAME, "R4 no gap",
                start_log[s0+1] - start_log[s0], FRAME);
      end

      // R3 random characters with random gaps
      for (int i = 0; i < 20; i++) begin
         put(DW'($urandom));
         cyc($urandom % 400);
      end
      wait_empty();

      // R6 break queued behind shifting, held and later-written chars
      begin
         int base, g;
         base = rx_total;
         put(8'h11);
         put(8'h22);
         pulse_bstart();
         put(8'h33);
         g = 0;
         while (brk_events == 0 && g < 20000) begin @(negedge clk); g++; end
         chk(brk_events == 1, "R6 break seen", brk_events, 1);
         chk(chars_at_brk == base + 3, "R6 break after all chars", chars_at_brk, base + 3);
         chk(txd == 1'b0, "R6 line low in break", int'(txd), 0);
         chk(empty == 1'b0, "R11 not empty in break", int'(empty), 0);
         wait_ticks(40);
         chk(txd == 1'b0, "R6 break holds", int'(txd), 0);
         pulse_bstop();
         g = 0;
         while (txd == 1'b0 && g < 32) begin wait_ticks(1); g++; end
         chk(txd == 1'b1, "R9 high within two bits", g, 32);
         put(8'h44);
         wait_rx(base + 4);
         wait_empty();
      end

      // R7 idle break begins quickly
      begin
         int g;
         pulse_bstart();
         g = 0;
         while (txd == 1'b1 && g < 40) begin wait_ticks(1); g++; end
         chk(g <= 2 * OV, "R7 idle break latency", g, 2 * OV);
         chk(empty == 1'b0, "R11 break not empty", int'(empty), 0);
         wait_ticks(200);
         pulse_bstop();
         wait_empty();
      end

      // R12 queued break cancelled, and same-cycle start/stop
      begin
         int b0;
         b0 = brk_events;
         put(8'h5E);
         pulse_bstart();
         pulse_bstop();
         wait_empty();
         brk_start = 1; brk_stop = 1; @(negedge clk); brk_start = 0; brk_stop = 0;
         wait_ticks(3 * OV);
         chk(txd == 1'b1, "R12 stop wins same cycle", int'(txd), 1);
         chk(brk_events == b0, "R12 no break", brk_events, b0);
         wait_empty();
      end

      // R10 graceful disable
      begin
         int base;
         base = rx_total;
         put(8'h81);
         put(8'h7E);
         pulse_dis();
         chk(rdy == 1'b0, "R10 rdy off", int'(rdy), 0);
         chk(empty == 1'b0, "R10 empty off", int'(empty), 0);
         wait_rx(base + 2);
         chk(rx_total == base + 2, "R10 pending chars sent", rx_total, base + 2);
      end

      // R5 write while disabled, R8 break while disabled
      begin
         int b0, r0;
         bit low;
         b0 = brk_events;
         r0 = rx_total;
         wait_ticks(2 * OV);
         wr_en = 1; wr_data = 8'h5A; @(negedge clk); wr_en = 0;
         pulse_bstart();
         low = 0;
         for (int k = 0; k < 4 * OV; k++) begin
            wait_ticks(1);
            if (txd == 1'b0) low = 1;
         end
         chk(low == 1'b0, "R8 no break when disabled", int'(low), 0);
         chk(rx_total == r0, "R5 disabled write ignored", rx_total, r0);
         chk(brk_events == b0, "R8 break count", brk_events, b0);
         pulse_en();
         chk(empty == 1'b1, "R5 nothing held after enable", int'(empty), 1);
      end

      wait_ticks(FRAME);
      chk(exp_q.size() == 0, "R3 all chars received", exp_q.size(), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule